// File: doc/BRIEF.md
# LIN Wake Request Filter

While a LIN transceiver sleeps, this block decides whether activity on two wake sources is a real wake request. It watches two digitized inputs. The first is the local wake switch level, which reads low once the pin sits well below supply and high while it stays near supply. The second is the bus receiver level, where low means dominant. Each input passes through a two-flop synchronizer. A counter then measures how long the input holds each level.

A local wake is accepted only in one case: the wake input has held high for a minimum time and then goes low for a minimum time. In that case the block sends a single-cycle pulse to the mode controller. It also raises a request to pull the TXD pin low, which tells the protocol controller that the wake came from the local switch. That request stays up until the mode controller leaves sleep.

A bus wake needs an unbroken dominant run of a minimum length. A parameter picks one of two variants. In the plain variant, any long enough dominant run is accepted. In the windowed variant, the long run must finish within a fixed window that opens at the first dominant sample. A late run is refused and stays refused until the bus goes recessive again. All times are parameters counted in clock ticks. Both filters are cleared and held idle whenever the sleep input is low.

Top module: `lin_wake_filter`

## Requirements
- R1: While reset is high, and in the cycle after it, local_wake_o, bus_wake_o and txd_pulldown_o are 0.
- R2: Take a change on an input pin as sample 1, reaching the filter two clocks later. Once the wake input is qualified high, the WAKE_LOW_TICKS-th consecutive low sample makes local_wake_o pulse for exactly one cycle. Counted from the clock edge after the pin fell, the pulse is visible after edge WAKE_LOW_TICKS+2.
- R3: A low run on the wake input produces no pulse unless the high run just before it lasted at least WAKE_HIGH_TICKS samples. A single high sample inside a low period breaks the qualification.
- R4: A low run shorter than WAKE_LOW_TICKS samples produces no pulse. A high sample restarts the low count. Each qualified low run yields at most one pulse.
- R5: txd_pulldown_o rises in the same cycle as a local_wake_o pulse. It stays 1 while sleep_i is 1.
- R6: bus_rx_i = 0 means dominant. The BUS_DOM_TICKS-th consecutive dominant sample makes bus_wake_o pulse for one cycle, visible after edge BUS_DOM_TICKS+2 from the fall. A recessive sample restarts the count. Each dominant run yields at most one pulse. With BUS_MODE = BUS_SIMPLE this is the only condition.
- R7: With BUS_MODE = BUS_FLOAT, a window opens at the first dominant sample seen while no window is active. The wake fires only if the dominant condition of R6 completes at window sample FLOAT_TICKS or earlier. If the window runs out during a dominant sample, no bus wake is given until a recessive sample arrives.
- R8: While sleep_i is 0, no wake pulse is produced and all counters stay cleared. txd_pulldown_o is 0 from the cycle after sleep_i falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_i | input | 1 | 1 while the mode controller is in sleep; arms both filters |
| wake_n_i | input | 1 | Digitized local wake level, 0 = switch active |
| bus_rx_i | input | 1 | Digitized bus level, 0 = dominant |
| local_wake_o | output | 1 | One-cycle pulse for an accepted local wake |
| bus_wake_o | output | 1 | One-cycle pulse for an accepted bus wake |
| txd_pulldown_o | output | 1 | Request to hold TXD low after a local wake |

## Verification
A broken high-run qualification or low counter shows at the ports as a local pulse that comes too early, comes when it should not, or never comes. That is visible within one low run of the wake input. A fault in the bus window state moves the acceptance point of a long dominant run compared with the window limit. Runs are therefore placed so that they complete exactly on the last window sample and one sample after it, which exposes an off-by-one in the next pulse. A pulldown latch or sleep gate that does not clear shows as txd_pulldown_o still high one cycle after sleep_i falls.

// File: rtl/wkf_pkg.sv
package wkf_pkg;

    typedef enum logic {
        BUS_SIMPLE = 1'b0,
        BUS_FLOAT  = 1'b1
    } bus_variant_e;

    typedef enum logic [1:0] {
        WIN_IDLE  = 2'd0,
        WIN_OPEN  = 2'd1,
        WIN_BLOCK = 2'd2
    } win_state_e;

    function automatic int cnt_w(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/wkf_sync.sv
module wkf_sync #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic s1, s2;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1 <= 1'b1;
                s2 <= 1'b1;
            end else begin
                s1 <= d[b];
                s2 <= s1;
            end
        end
        assign q[b] = s2;
    end
endmodule

// File: rtl/wkf_local_qual.sv
module wkf_local_qual
    import wkf_pkg::*;
#(
    parameter int HIGH_TICKS = 6,
    parameter int LOW_TICKS  = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic wake_lvl,
    output logic wake_pulse,
    output logic txd_pd
);
    localparam int HW = cnt_w(HIGH_TICKS);
    localparam int LW = cnt_w(LOW_TICKS);

    logic [HW-1:0] hi_cnt;
    logic [LW-1:0] lo_cnt;
    logic          qualified;

    always_ff @(posedge clk) begin
        if (rst || !arm) begin
            hi_cnt     <= '0;
            lo_cnt     <= '0;
            qualified  <= 1'b0;
            wake_pulse <= 1'b0;
            txd_pd     <= 1'b0;
        end else begin
            wake_pulse <= 1'b0;
            if (wake_lvl) begin
                lo_cnt <= '0;
                if (hi_cnt != HW'(HIGH_TICKS)) hi_cnt <= hi_cnt + 1'b1;
                qualified <= (hi_cnt >= HW'(HIGH_TICKS - 1));
            end else begin
                hi_cnt <= '0;
                if (qualified) begin
                    if (lo_cnt == LW'(LOW_TICKS - 1)) begin
                        wake_pulse <= 1'b1;
                        txd_pd     <= 1'b1;
                        qualified  <= 1'b0;
                    end else begin
                        lo_cnt <= lo_cnt + 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/wkf_bus_qual.sv
module wkf_bus_qual
    import wkf_pkg::*;
#(
    parameter int           DOM_TICKS   = 20,
    parameter int           FLOAT_TICKS = 60,
    parameter bus_variant_e BUS_MODE    = BUS_FLOAT
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic bus_lvl,
    output logic bus_pulse
);
    localparam int DW = cnt_w(DOM_TICKS);
    localparam int WW = cnt_w(FLOAT_TICKS);

    win_state_e    state;
    logic [DW-1:0] dom_cnt;
    logic [WW-1:0] win_cnt;
    logic          dominant, hit, win_ok, opens, fire;

    assign dominant = !bus_lvl;
    assign hit      = dominant && (dom_cnt == DW'(DOM_TICKS - 1));

    if (BUS_MODE == BUS_FLOAT) begin : g_float
        assign win_ok = (state == WIN_OPEN) || (state == WIN_IDLE);
        assign opens  = 1'b1;
    end else begin : g_plain
        assign win_ok = (state != WIN_BLOCK);
        assign opens  = 1'b0;
    end

    assign fire = hit && win_ok;

    always_ff @(posedge clk) begin
        if (rst || !arm) begin
            state     <= WIN_IDLE;
            dom_cnt   <= '0;
            win_cnt   <= '0;
            bus_pulse <= 1'b0;
        end else begin
            bus_pulse <= fire;
            if (!dominant)  dom_cnt <= '0;
            else if (!hit)  dom_cnt <= dom_cnt + 1'b1;
            case (state)
                WIN_IDLE: begin
                    if (fire) state <= WIN_BLOCK;
                    else if (dominant && opens) begin
                        state   <= WIN_OPEN;
                        win_cnt <= WW'(1);
                    end
                end
                WIN_OPEN: begin
                    if (fire) state <= WIN_BLOCK;
                    else if (win_cnt == WW'(FLOAT_TICKS - 1))
                        state <= dominant ? WIN_BLOCK : WIN_IDLE;
                    else win_cnt <= win_cnt + 1'b1;
                end
                default: begin
                    if (!dominant) state <= WIN_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/lin_wake_filter.sv
module lin_wake_filter
    import wkf_pkg::*;
#(
    parameter int           WAKE_HIGH_TICKS = 1200,
    parameter int           WAKE_LOW_TICKS  = 4000,
    parameter int           BUS_DOM_TICKS   = 18000,
    parameter int           FLOAT_TICKS     = 2000000,
    parameter bus_variant_e BUS_MODE        = BUS_FLOAT
) (
    input  logic clk,
    input  logic rst,
    input  logic sleep_i,
    input  logic wake_n_i,
    input  logic bus_rx_i,
    output logic local_wake_o,
    output logic bus_wake_o,
    output logic txd_pulldown_o
);
    logic [1:0] sync_q;
    logic       wake_s, bus_s;

    wkf_sync #(.WIDTH(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({wake_n_i, bus_rx_i}),
        .q   (sync_q)
    );

    assign wake_s = sync_q[1];
    assign bus_s  = sync_q[0];

    wkf_local_qual #(
        .HIGH_TICKS (WAKE_HIGH_TICKS),
        .LOW_TICKS  (WAKE_LOW_TICKS)
    ) u_local (
        .clk        (clk),
        .rst        (rst),
        .arm        (sleep_i),
        .wake_lvl   (wake_s),
        .wake_pulse (local_wake_o),
        .txd_pd     (txd_pulldown_o)
    );

    wkf_bus_qual #(
        .DOM_TICKS   (BUS_DOM_TICKS),
        .FLOAT_TICKS (FLOAT_TICKS),
        .BUS_MODE    (BUS_MODE)
    ) u_bus (
        .clk       (clk),
        .rst       (rst),
        .arm       (sleep_i),
        .bus_lvl   (bus_s),
        .bus_pulse (bus_wake_o)
    );
endmodule

// File: rtl/wkf_checker.sv
module wkf_checker (
    input logic clk,
    input logic rst,
    input logic sleep_i,
    input logic wake_s,
    input logic bus_s,
    input logic local_wake_o,
    input logic bus_wake_o,
    input logic txd_pulldown_o
);
    // R1
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!local_wake_o && !bus_wake_o && !txd_pulldown_o));

    // R2, R4
    a_r2_local_single: assert property (@(posedge clk) disable iff (rst)
        local_wake_o |=> !local_wake_o);

    // R2
    a_r2_local_after_low: assert property (@(posedge clk) disable iff (rst)
        local_wake_o |-> !$past(wake_s));

    // R6
    a_r6_bus_single: assert property (@(posedge clk) disable iff (rst)
        bus_wake_o |=> !bus_wake_o);

    // R6
    a_r6_bus_after_dom: assert property (@(posedge clk) disable iff (rst)
        bus_wake_o |-> !$past(bus_s));

    // R5
    a_r5_set_on_wake: assert property (@(posedge clk) disable iff (rst)
        $rose(txd_pulldown_o) |-> local_wake_o);

    // R5
    a_r5_hold_in_sleep: assert property (@(posedge clk) disable iff (rst)
        (txd_pulldown_o && sleep_i) |=> txd_pulldown_o);

    // R8
    a_r8_quiet_awake: assert property (@(posedge clk) disable iff (rst)
        !sleep_i |=> (!local_wake_o && !bus_wake_o && !txd_pulldown_o));
endmodule

bind lin_wake_filter wkf_checker u_chk (
    .clk            (clk),
    .rst            (rst),
    .sleep_i        (sleep_i),
    .wake_s         (wake_s),
    .bus_s          (bus_s),
    .local_wake_o   (local_wake_o),
    .bus_wake_o     (bus_wake_o),
    .txd_pulldown_o (txd_pulldown_o)
);

// File: tb/sim_lin_wake_filter.sv
`timescale 1ns/1ps
module sim_lin_wake_filter;
    import wkf_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sleep = 1'b1;
    logic wake_n = 1'b1;
    logic bus_rx = 1'b1;
    logic l0, b0, t0, l1, b1, t1;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    lin_wake_filter #(
        .WAKE_HIGH_TICKS (6),
        .WAKE_LOW_TICKS  (10),
        .BUS_DOM_TICKS   (20),
        .FLOAT_TICKS     (60),
        .BUS_MODE        (BUS_FLOAT)
    ) u0 (
        .clk (clk), .rst (rst), .sleep_i (sleep), .wake_n_i (wake_n),
        .bus_rx_i (bus_rx), .local_wake_o (l0), .bus_wake_o (b0),
        .txd_pulldown_o (t0)
    );

    lin_wake_filter #(
        .WAKE_HIGH_TICKS (6),
        .WAKE_LOW_TICKS  (10),
        .BUS_DOM_TICKS   (20),
        .FLOAT_TICKS     (60),
        .BUS_MODE        (BUS_SIMPLE)
    ) u1 (
        .clk (clk), .rst (rst), .sleep_i (sleep), .wake_n_i (wake_n),
        .bus_rx_i (bus_rx), .local_wake_o (l1), .bus_wake_o (b1),
        .txd_pulldown_o (t1)
    );

    // {sel (0 local, 1 bus), level, cycles, first pulse u0, first pulse u1}
    localparam int NVEC = 32;
    localparam logic [33:0] VEC [NVEC] = '{
        {1'b0, 1'b1, 16'd20, 8'd0,  8'd0 },
        {1'b0, 1'b0, 16'd5,  8'd0,  8'd0 },
        {1'b0, 1'b1, 16'd3,  8'd0,  8'd0 },
        {1'b0, 1'b0, 16'd15, 8'd0,  8'd0 },
        {1'b0, 1'b1, 16'd10, 8'd0,  8'd0 },
        {1'b0, 1'b0, 16'd15, 8'd12, 8'd12},
        {1'b0, 1'b1, 16'd10, 8'd0,  8'd0 },
        {1'b1, 1'b0, 16'd25, 8'd22, 8'd22},
        {1'b1, 1'b1, 16'd10, 8'd0,  8'd0 },
        {1'b1, 1'b0, 16'd5,  8'd0,  8'd0 },
        {1'b1, 1'b1, 16'd40, 8'd0,  8'd0 },
        {1'b1, 1'b0, 16'd30, 8'd0,  8'd22},
        {1'b1, 1'b1, 16'd10, 8'd0,  8'd0 },
        {1'b1, 1'b0, 16'd25, 8'd22, 8'd22},
        {1'b1, 1'b1, 16'd10, 8'd0,  8'd0 },
        {1'b1, 1'b0, 16'd5,  8'd0,  8'd0 },
        {1'b1, 1'b1, 16'd35, 8'd0,  8'd0 },
        {1'b1, 1'b0, 16'd30, 8'd22, 8'd22},
        {1'b1, 1'b1, 16'd10, 8'd0,  8'd0 },
        {1'b1, 1'b0, 16'd5,  8'd0,  8'd0 },
        {1'b1, 1'b1, 16'd36, 8'd0,  8'd0 },
        {1'b1, 1'b0, 16'd30, 8'd0,  8'd22},
        {1'b1, 1'b1, 16'd10, 8'd0,  8'd0 },
        {1'b1, 1'b0, 16'd15, 8'd0,  8'd0 },
        {1'b1, 1'b1, 16'd1,  8'd0,  8'd0 },
        {1'b1, 1'b0, 16'd25, 8'd22, 8'd22},
        {1'b1, 1'b1, 16'd10, 8'd0,  8'd0 },
        {1'b0, 1'b1, 16'd10, 8'd0,  8'd0 },
        {1'b0, 1'b0, 16'd8,  8'd0,  8'd0 },
        {1'b0, 1'b1, 16'd1,  8'd0,  8'd0 },
        {1'b0, 1'b0, 16'd15, 8'd0,  8'd0 },
        {1'b0, 1'b1, 16'd10, 8'd0,  8'd0 }
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic hold(input bit sel, input bit lvl, input int len,
                        output int f0, output int c0,
                        output int f1, output int c1);
        if (sel) bus_rx = lvl; else wake_n = lvl;
        f0 = 0; c0 = 0; f1 = 0; c1 = 0;
        for (int i = 1; i <= len; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (sel ? b0 : l0) begin c0++; if (f0 == 0) f0 = i; end
            if (sel ? b1 : l1) begin c1++; if (f1 == 0) f1 = i; end
        end
    endtask

    initial begin
        int f0, c0, f1, c1;
        string tag;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R1 local_wake u0", int'(l0), 0);
        chk("R1 bus_wake u0", int'(b0), 0);
        chk("R1 txd_pulldown u0", int'(t0), 0);
        chk("R1 outputs u1", int'({l1, b1, t1}), 0);
        rst = 1'b0;

        for (int k = 0; k < NVEC; k++) begin
            hold(VEC[k][33], VEC[k][32], int'(VEC[k][31:16]), f0, c0, f1, c1);
            if (VEC[k][33])
                tag = (VEC[k][15:8] != VEC[k][7:0]) ? "R7" : "R6";
            else
                tag = (VEC[k][15:8] != 0) ? "R2" : "R3,R4";
            chk($sformatf("%s entry %0d first pulse u0", tag, k), f0, int'(VEC[k][15:8]));
            chk($sformatf("%s entry %0d first pulse u1", tag, k), f1, int'(VEC[k][7:0]));
            chk($sformatf("R4 entry %0d pulse count u0", k), c0, (VEC[k][15:8] != 0) ? 1 : 0);
            chk($sformatf("R4 entry %0d pulse count u1", k), c1, (VEC[k][7:0] != 0) ? 1 : 0);
            chk($sformatf("R5 entry %0d txd_pulldown", k), int'({t0, t1}), (k >= 5) ? 3 : 0);
        end

        sleep = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R8 txd_pulldown cleared", int'({t0, t1}), 0);
        hold(1'b0, 1'b1, 10, f0, c0, f1, c1);
        hold(1'b0, 1'b0, 15, f0, c0, f1, c1);
        chk("R8 no local wake awake", c0 + c1, 0);
        hold(1'b0, 1'b1, 10, f0, c0, f1, c1);
        hold(1'b1, 1'b0, 25, f0, c0, f1, c1);
        chk("R8 no bus wake awake", c0 + c1, 0);
        chk("R8 txd_pulldown stays low", int'({t0, t1}), 0);
        hold(1'b1, 1'b1, 10, f0, c0, f1, c1);

        sleep = 1'b1;
        hold(1'b0, 1'b1, 10, f0, c0, f1, c1);
        hold(1'b0, 1'b0, 15, f0, c0, f1, c1);
        chk("R2 rearmed local wake u0", f0, 12);
        chk("R2 rearmed local wake u1", f1, 12);
        chk("R5 txd_pulldown after rearm", int'({t0, t1}), 3);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule